// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor's 16-bit address bus and the two external storage arrays of a plug-in cartridge: a ROM of up to 128 banks of 16 KiB and an optional, non-battery-backed RAM of 8 KiB banks. The processor cannot write ROM. Instead, its stores into the lower half of the address space program four small control registers: a RAM enable flag, a 7-bit ROM bank number, a 2-bit auxiliary bank field and a one-bit banking mode. Loads return ROM data, RAM data, or 0xFF for anything unmapped or switched off.

The banking mode decides how the auxiliary field is used. With mode clear it touches neither path, and RAM is always bank 0. With mode set it becomes bits 6:5 of the switchable ROM bank and also picks the RAM bank. The ROM and RAM bank counts are powers of two given as parameters, so the wrap to the fitted bank count is a plain truncation.

All four registers can be read out at once as a 32-bit word and reloaded in one cycle. This lets a host suspend and resume the cartridge state. Strobes and addresses leave the block registered. Read data comes back two cycles after the request, flagged by a valid pulse.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous reset all four control registers are zero, so `save_data` is 0 and a load from 0x4000 returns bank 1 data.
- R2: A store with `cpu_addr[15]`=0 writes the register chosen by `cpu_addr[14:13]` (0 RAM enable, 1 ROM bank, 2 auxiliary bank, 3 mode). The ROM bank keeps `cpu_wdata[6:0]`, the auxiliary field keeps `cpu_wdata[1:0]` and the mode keeps `cpu_wdata[0]`.
- R3: The RAM enable flag becomes 1 only when `cpu_wdata[3:0]` is 4'hA; any other low nibble clears it.
- R4: Loads from 0x0000–0x3FFF use ROM bank 0. `rom_addr` is {bank, `cpu_addr[13:0]`}.
- R5: A ROM bank register value of 0 selects bank 1 in the 0x4000–0x7FFF window; this substitution happens before the mode merge.
- R6: With mode set, the switchable bank is {auxiliary[1:0], substituted bank[4:0]}. Bank 0 can result from this.
- R7: The switchable bank number is reduced modulo ROM_BANKS by keeping its low log2(ROM_BANKS) bits.
- R8: Accesses to 0xA000–0xBFFF use RAM bank 0 when mode is clear, and auxiliary modulo RAM_BANKS when mode is set. `ram_addr` is {bank, `cpu_addr[12:0]`}.
- R9: While RAM is disabled or absent, RAM-window loads return 0xFF and stores never raise `ram_we`. Loads from 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF, and stores there change nothing.
- R10: `save_data` holds byte 0 = ROM bank, byte 1 = auxiliary, byte 2 = mode, byte 3 = RAM enable (byte k at bits 8k+7:8k). `restore_en` loads all four in one cycle: ROM bank from byte0[6:0], auxiliary from byte1[1:0], mode and enable set when their byte is nonzero. Restore wins over a register store in the same cycle.
- R11: Strobes and addresses appear on the edge after the request. `cpu_rdata` is valid with `cpu_rvalid` two edges after `cpu_rd`. A store takes priority over a load in the same cycle, and a register store affects the very next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor store data |
| cpu_wr | input | 1 | One-cycle store strobe |
| cpu_rd | input | 1 | One-cycle load strobe |
| cpu_rdata | output | 8 | Load data |
| cpu_rvalid | output | 1 | Load data valid |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_cs | output | 1 | ROM read select |
| rom_rdata | input | 8 | ROM data for `rom_addr` |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data for `ram_addr` |
| save_data | output | 32 | Packed control registers |
| restore_en | input | 1 | Load all registers from `restore_data` |
| restore_data | input | 32 | Packed register image to load |

## Verification
Two cases are hard to reach. The first is a mode-set merge that lands on ROM bank 0, or that drops auxiliary bit 6 through the bank-count wrap. The bench reaches them by programming the ROM bank to 0x20 and 0x03 with chosen auxiliary values, then loading from the switchable window. The second is a RAM store that is silently dropped. It cannot be seen directly, so the bench disables RAM, stores to a location with known contents, re-enables RAM and reads the location back. RAM contents written in one auxiliary bank are also read back after switching banks and modes, which shows that mode-clear accesses ignore the auxiliary field.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    SRC_OPEN = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic [6:0] rom_bank;
    logic [1:0] aux;
    logic       mode;
    logic       ram_en;
  } ctl_s;

  localparam logic [3:0] RAM_KEY   = 4'hA;
  localparam int         ROM_OFS_W = 14;
  localparam int         RAM_OFS_W = 13;
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        restore_en,
  input  logic [31:0] restore_data,
  output ctl_s        ctl
);
  logic unused_bits;
  assign unused_bits = ^{restore_data[7], restore_data[15:10], wr_data[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (restore_en) begin
      ctl.rom_bank <= restore_data[6:0];
      ctl.aux      <= restore_data[9:8];
      ctl.mode     <= |restore_data[23:16];
      ctl.ram_en   <= |restore_data[31:24];
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    ctl.ram_en   <= (wr_data[3:0] == RAM_KEY);
        2'd1:    ctl.rom_bank <= wr_data[6:0];
        2'd2:    ctl.aux      <= wr_data[1:0];
        default: ctl.mode     <= wr_data[0];
      endcase
    end
  end
endmodule

// File: rtl/cbc_map.sv
module cbc_map
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  parameter bit HAS_RAM   = 1'b1,
  localparam int ROM_BW = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int ROM_AW = ROM_BW + ROM_OFS_W,
  localparam int RAM_AW = RAM_BW + RAM_OFS_W
) (
  input  logic [15:0]       addr,
  input  ctl_s              ctl,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              in_rom,
  output logic              ram_ok
);
  logic [6:0]        base_bank;
  logic [6:0]        merged_bank;
  logic [ROM_BW-1:0] sw_bank;
  logic [RAM_BW-1:0] ram_bank;

  always_comb begin
    base_bank   = (ctl.rom_bank == 7'd0) ? 7'd1 : ctl.rom_bank;
    merged_bank = ctl.mode ? {ctl.aux, base_bank[4:0]} : base_bank;
  end

  generate
    if (ROM_BANKS > 1) begin : g_rom_wrap
      assign sw_bank = ROM_BW'(merged_bank);
    end else begin : g_rom_single
      logic unused_merged;
      assign unused_merged = ^merged_bank;
      assign sw_bank = '0;
    end

    if (RAM_BANKS > 1) begin : g_ram_wrap
      assign ram_bank = ctl.mode ? RAM_BW'(ctl.aux) : '0;
    end else begin : g_ram_single
      assign ram_bank = '0;
    end
  endgenerate

  assign rom_addr = {(addr[14] ? sw_bank : {ROM_BW{1'b0}}), addr[13:0]};
  assign ram_addr = {ram_bank, addr[12:0]};
  assign in_rom   = ~addr[15];
  assign ram_ok   = HAS_RAM && (addr[15:13] == 3'b101) && ctl.ram_en;
endmodule

// File: rtl/cbc_bus.sv
module cbc_bus
  import cbc_pkg::*;
#(
  parameter int ROM_AW = 20,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic              in_rom,
  input  logic              ram_ok,
  input  logic [ROM_AW-1:0] rom_addr_d,
  input  logic [RAM_AW-1:0] ram_addr_d,
  input  logic [7:0]        wdata,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rvalid
);
  rd_src_e src_q;
  logic    pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs     <= 1'b0;
      rom_addr   <= '0;
      ram_cs     <= 1'b0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      cpu_rdata  <= 8'hFF;
      cpu_rvalid <= 1'b0;
      src_q      <= SRC_OPEN;
      pend_q     <= 1'b0;
    end else begin
      rom_cs <= rd && in_rom;
      ram_cs <= (rd || wr) && ram_ok;
      ram_we <= wr && ram_ok;
      if (rd && in_rom) rom_addr <= rom_addr_d;
      if ((rd || wr) && ram_ok) ram_addr <= ram_addr_d;
      if (wr) ram_wdata <= wdata;
      pend_q <= rd;
      if (rd) src_q <= in_rom ? SRC_ROM : (ram_ok ? SRC_RAM : SRC_OPEN);
      else    src_q <= SRC_OPEN;
      cpu_rvalid <= pend_q;
      if (pend_q) begin
        case (src_q)
          SRC_ROM: cpu_rdata <= rom_rdata;
          SRC_RAM: cpu_rdata <= ram_rdata;
          default: cpu_rdata <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  parameter bit HAS_RAM   = 1'b1,
  localparam int ROM_AW = ((ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1) + ROM_OFS_W,
  localparam int RAM_AW = ((RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1) + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rvalid,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  input  logic [7:0]        rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic [31:0]       save_data,
  input  logic              restore_en,
  input  logic [31:0]       restore_data
);
  ctl_s              ctl;
  logic              rd_req;
  logic              reg_wr;
  logic              in_rom;
  logic              ram_ok;
  logic [ROM_AW-1:0] rom_addr_d;
  logic [RAM_AW-1:0] ram_addr_d;

  assign rd_req = cpu_rd && !cpu_wr;
  assign reg_wr = cpu_wr && !cpu_addr[15];

  cbc_regs i_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr),
    .wr_sel       (cpu_addr[14:13]),
    .wr_data      (cpu_wdata),
    .restore_en   (restore_en),
    .restore_data (restore_data),
    .ctl          (ctl)
  );

  cbc_map #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_BANKS (RAM_BANKS),
    .HAS_RAM   (HAS_RAM)
  ) i_map (
    .addr     (cpu_addr),
    .ctl      (ctl),
    .rom_addr (rom_addr_d),
    .ram_addr (ram_addr_d),
    .in_rom   (in_rom),
    .ram_ok   (ram_ok)
  );

  cbc_bus #(
    .ROM_AW (ROM_AW),
    .RAM_AW (RAM_AW)
  ) i_bus (
    .clk        (clk),
    .rst        (rst),
    .rd         (rd_req),
    .wr         (cpu_wr),
    .in_rom     (in_rom),
    .ram_ok     (ram_ok),
    .rom_addr_d (rom_addr_d),
    .ram_addr_d (ram_addr_d),
    .wdata      (cpu_wdata),
    .rom_rdata  (rom_rdata),
    .ram_rdata  (ram_rdata),
    .rom_cs     (rom_cs),
    .rom_addr   (rom_addr),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .cpu_rdata  (cpu_rdata),
    .cpu_rvalid (cpu_rvalid)
  );

  assign save_data = {7'd0, ctl.ram_en, 7'd0, ctl.mode, 6'd0, ctl.aux, 1'b0, ctl.rom_bank};
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ROM_AW = 20,
  parameter int RAM_AW = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              cpu_rvalid,
  input logic              rom_cs,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_cs,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [31:0]       save_data,
  input logic              restore_en,
  input logic [31:0]       restore_data
);
  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(cpu_rd && !cpu_wr, 2));

  a_r4_fixed_window: assert property (@(posedge clk) disable iff (rst)
    (rom_cs && !$past(cpu_addr[14])) |-> (rom_addr[ROM_AW-1:14] == '0));

  a_r8_mode0_ram_bank: assert property (@(posedge clk) disable iff (rst)
    (ram_cs && !$past(save_data[16])) |-> (ram_addr[RAM_AW-1:13] == '0));

  a_r9_no_write_disabled: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(save_data[24]) && $past(cpu_wr && cpu_addr[15:13] == 3'b101)));

  a_r10_restore_load: assert property (@(posedge clk) disable iff (rst)
    $past(restore_en) |-> (save_data[6:0] == $past(restore_data[6:0]) &&
                           save_data[9:8] == $past(restore_data[9:8]) &&
                           save_data[16]  == $past(|restore_data[23:16]) &&
                           save_data[24]  == $past(|restore_data[31:24])));
endmodule

bind cart_bank_ctrl cbc_checker #(
  .ROM_AW (ROM_AW),
  .RAM_AW (RAM_AW)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_addr     (cpu_addr),
  .cpu_wr       (cpu_wr),
  .cpu_rd       (cpu_rd),
  .cpu_rvalid   (cpu_rvalid),
  .rom_cs       (rom_cs),
  .rom_addr     (rom_addr),
  .ram_cs       (ram_cs),
  .ram_we       (ram_we),
  .ram_addr     (ram_addr),
  .save_data    (save_data),
  .restore_en   (restore_en),
  .restore_data (restore_data)
);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
  localparam int ROM_BANKS = 64;
  localparam int RAM_BANKS = 4;
  localparam int ROM_AW = $clog2(ROM_BANKS) + 14;
  localparam int RAM_AW = $clog2(RAM_BANKS) + 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_wr = 1'b0;
  logic              cpu_rd = 1'b0;
  logic [7:0]        cpu_rdata;
  logic              cpu_rvalid;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_cs;
  logic [7:0]        rom_rdata = '0;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_cs;
  logic              ram_we;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata = '0;
  logic [31:0]       save_data;
  logic              restore_en = 1'b0;
  logic [31:0]       restore_data = '0;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS), .HAS_RAM(1'b1)) i_cart_bank_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .rom_addr(rom_addr),
    .rom_cs(rom_cs), .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_cs(ram_cs),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .save_data(save_data),
    .restore_en(restore_en), .restore_data(restore_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // storage models outside the block
  logic [7:0] ram_mem [int];
  logic [7:0] exp_ram [int];

  function automatic logic [7:0] rom_pat(int bank, int ofs);
    return 8'(ofs) ^ 8'(bank * 5 + 3);
  endfunction

  always @(negedge clk) begin
    rom_rdata <= rom_pat(int'(rom_addr[ROM_AW-1:14]), int'(rom_addr[13:0]));
    ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
  end
  always @(posedge clk) if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;

  always @(posedge clk) cyc <= cyc + 1;

  // shadow of the control registers
  logic [6:0] s_rom = '0;
  logic [1:0] s_aux = '0;
  logic       s_mode = 1'b0;
  logic       s_en = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  int         iss_q [$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [15:0] a);
    logic [6:0] b;
    int         bank;
    int         ri;
    if (!a[15]) begin
      b = (s_rom == 0) ? 7'd1 : s_rom;
      if (s_mode) b = {s_aux, b[4:0]};
      bank = a[14] ? (int'(b) % ROM_BANKS) : 0;
      return rom_pat(bank, int'(a[13:0]));
    end
    if (a[15:13] == 3'b101 && s_en) begin
      ri = (s_mode ? int'(s_aux) % RAM_BANKS : 0) * 8192 + int'(a[12:0]);
      return exp_ram.exists(ri) ? exp_ram[ri] : 8'h00;
    end
    return 8'hFF;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    int ri;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    if (!a[15]) begin
      case (a[14:13])
        2'd0: s_en = (d[3:0] == 4'hA);
        2'd1: s_rom = d[6:0];
        2'd2: s_aux = d[1:0];
        default: s_mode = d[0];
      endcase
    end else if (a[15:13] == 3'b101 && s_en) begin
      ri = (s_mode ? int'(s_aux) % RAM_BANKS : 0) * 8192 + int'(a[12:0]);
      exp_ram[ri] = d;
    end
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    exp_q.push_back(model_rd(a));
    tag_q.push_back(tag);
    iss_q.push_back(cyc);
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic restore(logic [31:0] d, bit with_wr);
    @(negedge clk);
    restore_en = 1'b1; restore_data = d;
    if (with_wr) begin cpu_addr = 16'h2000; cpu_wdata = 8'h09; cpu_wr = 1'b1; end
    s_rom = d[6:0]; s_aux = d[9:8]; s_mode = |d[23:16]; s_en = |d[31:24];
    @(posedge clk); #1;
    restore_en = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic chk_save(string tag);
    logic [31:0] e;
    e = {7'd0, s_en, 7'd0, s_mode, 6'd0, s_aux, 1'b0, s_rom};
    chk(save_data === e, tag, save_data, e);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cpu_rvalid && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected rvalid", 32'(cpu_rdata), 32'hx);
      end else begin
        logic [7:0] e;
        string      t;
        int         i;
        e = exp_q.pop_front(); t = tag_q.pop_front(); i = iss_q.pop_front();
        chk(cpu_rdata === e, t, 32'(cpu_rdata), 32'(e));
        chk(cyc == i + 2, "R11 read latency", 32'(cyc - i), 32'd2);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk_save("R1 reset registers");
    rd(16'h4000, "R1 reset reads bank 1");
    rd(16'h0123, "R4 fixed bank 0 window");
    rd(16'hA000, "R9 RAM disabled read");
    rd(16'h8000, "R9 open 0x8000");
    rd(16'hC000, "R9 open 0xC000");
    rd(16'hFFFF, "R9 open 0xFFFF");
    drain();

    wr(16'h2000, 8'h05);
    rd(16'h4ABC, "R2 ROM bank 5 next cycle (R11)");
    wr(16'h3FFF, 8'h85);
    chk_save("R2 ROM bank keeps 7 bits");
    rd(16'h7FFF, "R2 bank 5 top offset");
    rd(16'h3FFF, "R4 fixed window ignores bank");
    wr(16'h2000, 8'h00);
    rd(16'h7FFF, "R5 bank 0 maps to 1");
    wr(16'h2000, 8'h7F);
    rd(16'h4001, "R7 bank 127 wraps to 63");
    wr(16'h2000, 8'h45);
    rd(16'h4002, "R7 bank 0x45 wraps to 5");
    drain();

    wr(16'h0000, 8'h1A);
    chk_save("R3 low nibble A enables");
    wr(16'h1FFF, 8'h0B);
    chk_save("R3 other nibble disables");
    wr(16'h0000, 8'h0A);
    chk_save("R3 re-enable");

    wr(16'hA010, 8'h11);
    wr(16'h4000, 8'h01);
    chk_save("R2 aux register");
    rd(16'hA010, "R8 mode 0 ignores aux");
    wr(16'h6000, 8'h01);
    chk_save("R2 mode register");
    wr(16'hA010, 8'h22);
    rd(16'hA010, "R8 mode 1 bank 1");
    wr(16'h4000, 8'h00);
    rd(16'hA010, "R8 mode 1 bank 0");
    wr(16'h4000, 8'hFF);
    chk_save("R2 aux keeps 2 bits");
    wr(16'hBFFF, 8'h33);
    rd(16'hBFFF, "R8 mode 1 bank 3 top");
    wr(16'h7FFF, 8'hFE);
    chk_save("R2 mode keeps bit 0");
    rd(16'hA010, "R8 back to bank 0");
    drain();

    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h01);
    wr(16'h2000, 8'h03);
    rd(16'h4010, "R6 merge aux=1 bank 3");
    wr(16'h4000, 8'h03);
    rd(16'h4011, "R7 merge bit 6 wrapped");
    wr(16'h4000, 8'h00);
    wr(16'h2000, 8'h20);
    rd(16'h4012, "R6 merge gives bank 0");
    wr(16'h4000, 8'h01);
    wr(16'h2000, 8'h00);
    rd(16'h4013, "R5 zero then merge");
    drain();

    wr(16'h4000, 8'h01);
    wr(16'h0000, 8'h00);
    wr(16'hA010, 8'h99);
    rd(16'hA010, "R9 disabled read");
    wr(16'h0000, 8'h0A);
    rd(16'hA010, "R9 dropped write kept old");
    wr(16'h8000, 8'h0A);
    wr(16'hC000, 8'h55);
    wr(16'hE000, 8'h0A);
    chk_save("R9 open stores ignored");
    rd(16'hA010, "R9 RAM intact after open stores");
    drain();

    restore(32'h8002_FD86, 1'b0);
    chk_save("R10 restore loads all");
    rd(16'h4000, "R10 restored bank used");
    restore(32'h0000_0012, 1'b1);
    chk_save("R10 restore beats store");
    restore(32'h0, 1'b0);
    chk_save("R10 restore zero");
    rd(16'hA010, "R10 restored disable");
    drain();

    chk(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule